// File: doc/BRIEF.md
# SDRAM Power-Down Clock-Enable Sequencer

This block decides when the SDRAM clock-enable (CKE) may be dropped and when it must be raised again. It watches the memory controller's request queues, the pending-refresh count and a flag that says all open pages have been closed. When power management is switched on, the array holds SDRAM and the controller has nothing left to do, the sequencer enters suspend. After a guard interval it drops CKE so the devices go into power-down.

While the devices are powered down, a few pending refreshes are left waiting. Once a full batch of refreshes has built up, the sequencer raises CKE and waits out the guard interval. It then opens the refresh path until the batch has drained, waits the guard interval again with CKE high, and drops CKE. Any read or write request, or power management being switched off, ends suspend. If CKE was low, CKE is raised and normal access is held off for the guard interval. The block does not issue precharge or refresh commands. It only drives CKE, a refresh-permitted strobe, an access-permitted strobe and a suspend status flag.

States are `PM_ACTIVE` (normal operation), `PM_ENTER` (suspend entered, CKE still high, guard running), `PM_POWERDOWN` (CKE low), `PM_WAKE_RF` (CKE raised for a refresh batch, guard running), `PM_DRAIN` (refreshes serviced back-to-back), `PM_SETTLE` (batch drained, CKE high, guard running) and `PM_WAKE_EXIT` (CKE raised to leave suspend, guard running). The transitions are:

- ACTIVE→ENTER on qualified idle.
- ENTER→POWERDOWN on guard end. ENTER→ACTIVE on wake. ENTER→DRAIN on a full batch.
- POWERDOWN→WAKE_EXIT on wake. POWERDOWN→WAKE_RF on a full batch.
- WAKE_RF→DRAIN on guard end. WAKE_RF→ACTIVE on guard end with wake pending.
- DRAIN→SETTLE when the refresh count reaches zero. DRAIN→ACTIVE on wake.
- SETTLE→POWERDOWN on guard end. SETTLE→ACTIVE on wake. SETTLE→DRAIN on a full batch.
- WAKE_EXIT→ACTIVE on guard end.

Top module: `sdram_cke_pm`

## Requirements
- R1: During and right after reset the block is in PM_ACTIVE with cke=1, refresh_allow=1, access_allow=1 and suspended=0.
- R2: PM_ACTIVE moves to PM_ENTER only if all of these hold: pm_enable=1, sdram_present=1, every bit of req_q_empty is 1 (1 means that queue is empty), rfq_count=0 and pages_closed=1. Otherwise it stays in PM_ACTIVE.
- R3: cke falls exactly GUARD_CYCLES (4) clocks after the clock on which suspended rose.
- R4: In power-down, an rfq_count below RF_BATCH (4) with no wake condition leaves cke=0 and refresh_allow=0.
- R5: When rfq_count reaches RF_BATCH in power-down, cke rises on the next clock and refresh_allow rises 4 clocks after that.
- R6: refresh_allow stays high during the drain until rfq_count=0. cke then stays high for 4 more clocks and falls.
- R7: A clear bit in req_q_empty during power-down raises cke on the next clock, and access_allow (with suspended=0) follows 4 clocks later.
- R8: Clearing pm_enable or sdram_present during power-down exits through the same sequence as R7.
- R9: A wake condition (R7 or R8) in PM_ENTER, PM_DRAIN or PM_SETTLE returns the block to PM_ACTIVE on the next clock.
- R10: If a wake condition and a full refresh batch arrive in the same power-down cycle, the exit path of R7 is taken and refresh_allow stays low until access_allow rises.
- R11: A wake condition during the refresh wake guard leads to PM_ACTIVE, not PM_DRAIN, when the guard ends.
- R12: suspended=0 only in PM_ACTIVE. access_allow=1 only in PM_ACTIVE. refresh_allow=1 only in PM_ACTIVE and PM_DRAIN. cke=0 only in PM_POWERDOWN.
- R13: rfq_count reaching RF_BATCH during PM_SETTLE or PM_ENTER goes straight to PM_DRAIN with no further guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_enable | input | 1 | Power-management enable bit |
| sdram_present | input | 1 | At least one populated row is SDRAM |
| req_q_empty | input | NUM_QUEUES | One bit per non-refresh request queue; 1 means the queue is empty |
| rfq_count | input | RFQ_W | Number of refreshes waiting in the refresh queue |
| pages_closed | input | 1 | All SDRAM pages are precharged |
| cke | output | 1 | SDRAM clock enable |
| refresh_allow | output | 1 | The refresh engine may issue refreshes |
| access_allow | output | 1 | Normal read/write access may proceed |
| suspended | output | 1 | The block is anywhere outside normal operation |

## Verification
Two functions can fall in the same cycle: waking for a refresh batch and exiting on a request. The bench provokes this by raising the refresh count to the batch size in the same cycle that a request queue goes non-empty during power-down. It also provokes a second case by bringing in a request while the refresh wake guard is already running. In both cases the outputs are judged four clocks later. The expected result is PM_ACTIVE (access permitted, suspend low), where a refresh-only path would have shown the drain state with access still blocked.

// File: rtl/cke_pm_pkg.sv
package cke_pm_pkg;

    typedef enum logic [2:0] {
        PM_ACTIVE     = 3'd0,
        PM_ENTER      = 3'd1,
        PM_POWERDOWN  = 3'd2,
        PM_WAKE_RF    = 3'd3,
        PM_DRAIN      = 3'd4,
        PM_SETTLE     = 3'd5,
        PM_WAKE_EXIT  = 3'd6
    } pm_state_e;

    typedef struct packed {
        logic cke;
        logic refresh_allow;
        logic suspended;
        logic access_allow;
    } pm_out_t;

endpackage

// File: rtl/cke_pm_qualify.sv
module cke_pm_qualify #(
    parameter int NUM_QUEUES = 2,
    parameter int RFQ_W      = 3,
    parameter int RF_BATCH   = 4
) (
    input  logic                  pm_enable,
    input  logic                  sdram_present,
    input  logic [NUM_QUEUES-1:0] req_q_empty,
    input  logic [RFQ_W-1:0]      rfq_count,
    input  logic                  pages_closed,
    output logic                  pm_on,
    output logic                  idle_all,
    output logic                  wake,
    output logic                  rf_batch,
    output logic                  rf_empty
);

    localparam logic [RFQ_W-1:0] BATCH_V = RFQ_W'(RF_BATCH);

    logic queues_idle;

    always_comb begin
        queues_idle = &req_q_empty;
        pm_on       = pm_enable & sdram_present;
        rf_empty    = (rfq_count == '0);
        rf_batch    = (rfq_count >= BATCH_V);
        idle_all    = queues_idle & rf_empty & pages_closed;
        // refresh demand never counts as a reason to leave suspend
        wake        = ~pm_on | ~queues_idle;
    end

endmodule

// File: rtl/cke_guard_timer.sv
module cke_guard_timer #(
    parameter int GUARD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);

    localparam int CW = (GUARD_CYCLES < 2) ? 1 : $clog2(GUARD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(GUARD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LAST);

endmodule

// File: rtl/cke_pm_fsm.sv
module cke_pm_fsm
    import cke_pm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    pm_on,
    input  logic    idle_all,
    input  logic    wake,
    input  logic    rf_batch,
    input  logic    rf_empty,
    input  logic    guard_done,
    output logic    restart,
    output pm_out_t outs
);

    pm_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PM_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_ACTIVE: begin
                if (pm_on && idle_all) state_d = PM_ENTER;
            end
            PM_ENTER: begin
                if (wake)            state_d = PM_ACTIVE;
                else if (rf_batch)   state_d = PM_DRAIN;
                else if (guard_done) state_d = PM_POWERDOWN;
            end
            PM_POWERDOWN: begin
                if (wake)            state_d = PM_WAKE_EXIT;
                else if (rf_batch)   state_d = PM_WAKE_RF;
            end
            PM_WAKE_RF: begin
                if (guard_done)      state_d = wake ? PM_ACTIVE : PM_DRAIN;
            end
            PM_DRAIN: begin
                if (wake)            state_d = PM_ACTIVE;
                else if (rf_empty)   state_d = PM_SETTLE;
            end
            PM_SETTLE: begin
                if (wake)            state_d = PM_ACTIVE;
                else if (rf_batch)   state_d = PM_DRAIN;
                else if (guard_done) state_d = PM_POWERDOWN;
            end
            PM_WAKE_EXIT: begin
                if (guard_done)      state_d = PM_ACTIVE;
            end
            default:                 state_d = PM_ACTIVE;
        endcase
    end

    assign restart = (state_d != state_q);

    // output decode
    always_comb begin
        outs = '{cke: 1'b1, refresh_allow: 1'b0, suspended: 1'b1, access_allow: 1'b0};
        unique case (state_q)
            PM_ACTIVE: begin
                outs.refresh_allow = 1'b1;
                outs.suspended     = 1'b0;
                outs.access_allow  = 1'b1;
            end
            PM_POWERDOWN: outs.cke           = 1'b0;
            PM_DRAIN:     outs.refresh_allow = 1'b1;
            PM_ENTER, PM_WAKE_RF, PM_SETTLE, PM_WAKE_EXIT: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_cke_pm.sv
module sdram_cke_pm
    import cke_pm_pkg::*;
#(
    parameter int NUM_QUEUES   = 2,
    parameter int RFQ_DEPTH    = 4,
    parameter int RF_BATCH     = RFQ_DEPTH,
    parameter int GUARD_CYCLES = 4,
    parameter int RFQ_W        = $clog2(RFQ_DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pm_enable,
    input  logic                  sdram_present,
    input  logic [NUM_QUEUES-1:0] req_q_empty,
    input  logic [RFQ_W-1:0]      rfq_count,
    input  logic                  pages_closed,
    output logic                  cke,
    output logic                  refresh_allow,
    output logic                  access_allow,
    output logic                  suspended
);

    logic    pm_on, idle_all, wake, rf_batch, rf_empty;
    logic    restart, guard_done;
    pm_out_t outs;

    cke_pm_qualify #(
        .NUM_QUEUES(NUM_QUEUES),
        .RFQ_W     (RFQ_W),
        .RF_BATCH  (RF_BATCH)
    ) u_qual (
        .pm_enable    (pm_enable),
        .sdram_present(sdram_present),
        .req_q_empty  (req_q_empty),
        .rfq_count    (rfq_count),
        .pages_closed (pages_closed),
        .pm_on        (pm_on),
        .idle_all     (idle_all),
        .wake         (wake),
        .rf_batch     (rf_batch),
        .rf_empty     (rf_empty)
    );

    cke_guard_timer #(
        .GUARD_CYCLES(GUARD_CYCLES)
    ) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .done   (guard_done)
    );

    cke_pm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pm_on     (pm_on),
        .idle_all  (idle_all),
        .wake      (wake),
        .rf_batch  (rf_batch),
        .rf_empty  (rf_empty),
        .guard_done(guard_done),
        .restart   (restart),
        .outs      (outs)
    );

    assign cke           = outs.cke;
    assign refresh_allow = outs.refresh_allow;
    assign access_allow  = outs.access_allow;
    assign suspended     = outs.suspended;

endmodule

// File: rtl/cke_pm_checker.sv
module cke_pm_checker #(
    parameter int NUM_QUEUES   = 2,
    parameter int RFQ_W        = 3,
    parameter int RF_BATCH     = 4,
    parameter int GUARD_CYCLES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pm_enable,
    input logic                  sdram_present,
    input logic [NUM_QUEUES-1:0] req_q_empty,
    input logic [RFQ_W-1:0]      rfq_count,
    input logic                  cke,
    input logic                  refresh_allow,
    input logic                  access_allow,
    input logic                  suspended
);

    localparam int HW = $clog2(GUARD_CYCLES + 1);
    localparam logic [HW-1:0] SAT = HW'(GUARD_CYCLES);

    // consecutive sampled cycles with cke high, saturating
    logic [HW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)         hi_cnt <= SAT;
        else if (!cke)      hi_cnt <= '0;
        else if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
    end

    logic quiet;
    assign quiet = pm_enable & sdram_present & (&req_q_empty);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cke && refresh_allow && access_allow && !suspended));

    p_cke_drop_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (hi_cnt >= SAT && suspended));

    p_hold_low_refresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && quiet && rfq_count < RFQ_W'(RF_BATCH)) |=> !cke);

    p_batch_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && rfq_count >= RFQ_W'(RF_BATCH)) |=> cke);

    p_refresh_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_allow |-> hi_cnt >= SAT);

    p_req_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !(&req_q_empty)) |=> cke);

    p_access_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        access_allow |-> hi_cnt >= SAT);

    p_disable_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !(pm_enable && sdram_present)) |=> cke);

    p_low_cke_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (suspended && !refresh_allow && !access_allow));

    p_access_only_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
        access_allow |-> (!suspended && cke && refresh_allow));

endmodule

bind sdram_cke_pm cke_pm_checker #(
    .NUM_QUEUES  (NUM_QUEUES),
    .RFQ_W       (RFQ_W),
    .RF_BATCH    (RF_BATCH),
    .GUARD_CYCLES(GUARD_CYCLES)
) u_chk (.*);

// File: tb/tb_sdram_cke_pm.sv
module tb_sdram_cke_pm;

    localparam int NV = 32;
    // vector: en sdp qe[1:0] rfq[2:0] pc | cke rfa susp acc
    localparam logic [11:0] VEC [NV] = '{
        12'b1_1_01_000_1_1101, // 0  busy queue
        12'b1_1_11_000_0_1101, // 1  pages open
        12'b1_1_11_001_1_1101, // 2  refresh pending
        12'b1_1_11_000_1_1010, // 3  enter
        12'b1_1_11_000_1_1010,
        12'b1_1_11_000_1_1010,
        12'b1_1_11_000_1_1010,
        12'b1_1_11_000_1_0010, // 7  cke low
        12'b1_1_11_001_1_0010,
        12'b1_1_11_011_1_0010,
        12'b1_1_11_100_1_1010, // 10 batch wake
        12'b1_1_11_100_1_1010,
        12'b1_1_11_100_1_1010,
        12'b1_1_11_100_1_1010,
        12'b1_1_11_100_1_1110, // 14 drain
        12'b1_1_11_011_1_1110,
        12'b1_1_11_010_1_1110,
        12'b1_1_11_001_1_1110,
        12'b1_1_11_000_1_1010, // 18 settle
        12'b1_1_11_000_1_1010,
        12'b1_1_11_000_1_1010,
        12'b1_1_11_000_1_1010,
        12'b1_1_11_000_1_0010, // 22 cke low again
        12'b1_1_10_000_1_1010, // 23 request exit
        12'b1_1_10_000_1_1010,
        12'b1_1_10_000_1_1010,
        12'b1_1_10_000_1_1010,
        12'b1_1_10_000_1_1101, // 27 active
        12'b1_1_11_000_1_1010, // 28 enter
        12'b0_1_11_000_1_1101, // 29 disable in entry guard
        12'b0_1_11_000_1_1101,
        12'b1_0_11_000_1_1101  // 31 no sdram
    };

    localparam logic [3:0] O_ACT   = 4'b1101;
    localparam logic [3:0] O_GUARD = 4'b1010;
    localparam logic [3:0] O_PD    = 4'b0010;
    localparam logic [3:0] O_DRAIN = 4'b1110;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pm_enable = 1'b1;
    logic       sdram_present = 1'b1;
    logic [1:0] req_q_empty = 2'b11;
    logic [2:0] rfq_count = 3'd0;
    logic       pages_closed = 1'b1;
    logic       cke, refresh_allow, access_allow, suspended;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    sdram_cke_pm dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pm_enable    (pm_enable),
        .sdram_present(sdram_present),
        .req_q_empty  (req_q_empty),
        .rfq_count    (rfq_count),
        .pages_closed (pages_closed),
        .cke          (cke),
        .refresh_allow(refresh_allow),
        .access_allow (access_allow),
        .suspended    (suspended)
    );

    function automatic string vtag(int i);
        if (i <= 2)       return "R2";
        else if (i <= 7)  return "R3";
        else if (i <= 9)  return "R4";
        else if (i <= 14) return "R5";
        else if (i <= 22) return "R6";
        else if (i <= 27) return "R7";
        else if (i <= 30) return "R9";
        else              return "R12";
    endfunction

    task automatic chk(input logic [3:0] exp, input string tag);
        logic [3:0] act;
        act = {cke, refresh_allow, suspended, access_allow};
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: {cke,rfa,susp,acc} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic set_in(input logic [7:0] v);
        {pm_enable, sdram_present, req_q_empty, rfq_count, pages_closed} = v;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        set_in(8'b1_1_01_000_1);
        step();
        step();
        rst_n = 1'b1;
    endtask

    // reach PM_POWERDOWN from a fresh reset
    task automatic goto_pd();
        do_reset();
        set_in(8'b1_1_11_000_1);
        repeat (5) step();
        chk(O_PD, "R3");
    endtask

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        // R1: reset state, during and after reset
        rst_n = 1'b0;
        set_in(8'b1_1_11_000_1);
        step();
        step();
        chk(O_ACT, "R1");
        set_in(8'b1_1_01_000_1);
        rst_n = 1'b1;
        step();
        chk(O_ACT, "R1");

        for (int i = 0; i < NV; i++) begin
            set_in(VEC[i][11:4]);
            step();
            chk(VEC[i][3:0], vtag(i));
        end

        // R8: enable cleared in power-down
        goto_pd();
        set_in(8'b0_1_11_000_1);
        step();
        chk(O_GUARD, "R8");
        repeat (2) step();
        step();
        chk(O_GUARD, "R8");
        step();
        chk(O_ACT, "R8");

        // R10: request and full batch in the same power-down cycle
        goto_pd();
        set_in(8'b1_1_01_100_1);
        step();
        chk(O_GUARD, "R10");
        repeat (3) step();
        chk(O_GUARD, "R10");
        step();
        chk(O_ACT, "R10");

        // R4 then R11: sub-batch wait, then request during refresh wake guard
        goto_pd();
        set_in(8'b1_1_11_011_0);
        repeat (6) step();
        chk(O_PD, "R4");
        set_in(8'b1_1_11_100_1);
        step();
        chk(O_GUARD, "R11");
        set_in(8'b1_1_10_100_1);
        repeat (2) step();
        chk(O_GUARD, "R11");
        step();
        step();
        chk(O_ACT, "R11");

        // R9: request during entry guard
        do_reset();
        set_in(8'b1_1_11_000_1);
        step();
        chk(O_GUARD, "R9");
        set_in(8'b1_1_01_000_1);
        step();
        chk(O_ACT, "R9");

        // R13: full batch during settle goes straight to drain
        goto_pd();
        set_in(8'b1_1_11_100_1);
        repeat (5) step();
        chk(O_DRAIN, "R5");
        set_in(8'b1_1_11_000_1);
        step();
        chk(O_GUARD, "R6");
        set_in(8'b1_1_11_100_1);
        step();
        chk(O_DRAIN, "R13");
        // R9: request during drain
        set_in(8'b1_1_01_010_1);
        step();
        chk(O_ACT, "R9");

        // R8: sdram flag dropped in power-down
        goto_pd();
        set_in(8'b1_0_11_000_1);
        step();
        chk(O_GUARD, "R8");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule